// File: doc/BRIEF.md
# Serial Byte-Memory SPI Slave

This block is an SPI slave that fronts a byte-wide, byte-addressed memory array. The array is held in on-chip registers and works like a small serial nonvolatile store. The host drives a serial clock, a chip select, a data input line and an active-low pause line. The block samples all of them in its own system clock domain through two-flop synchronizers and finds serial clock edges from the synchronized value. It works in SPI modes 0 and 3. Each frame opens with an 8-bit command, sent MSB first. Array accesses then carry a 16-bit address, of which only the low `AW` bits are used. Reads stream bytes out in order. Writes go into a page buffer and reach the array only during a self-timed write cycle.

A write cycle starts only if two things hold. First, the write-enable flag was set in an earlier frame. Second, chip select rises right after the last bit of a whole data byte. During the cycle the buffered bytes are copied into the array, one per clock, and a busy flag stays raised for `WCYC` clocks. The busy flag can be read through the status command. A protection unit holds two block-protect bits and a protect-enable bit, and it also reads a write-protect pin. Together these decide whether the status register can be written and which quarter of the array is locked. The defaults give a 2K-byte array. Setting `AW` to 13 gives 8K bytes.

Top module: `spi_eep_slave`

## Requirements
- R1: Command bytes: 0x06 sets the write-enable flag, 0x04 clears it, 0x05 streams the status byte (repeating), 0x01 writes status, 0x03 reads the array, 0x02 writes the array. Any other value makes the rest of the frame be ignored.
- R2: SI is sampled on rising SCK, and SO changes only after falling SCK. Every field goes MSB first. Both idle levels of SCK (modes 0 and 3) give the same results.
- R3: Commands 0x03 and 0x02 take a 16-bit address, and only its low `AW` bits are used. A read returns the byte at that address and then the following bytes. The address wraps from the top of the array to 0.
- R4: A write gathers 1 to `PAGE` bytes. The pointer wraps from the end of its page back to the page start, and a later byte replaces an earlier one at the same offset.
- R5: A write cycle (array or status) starts only when chip select rises right after bit 0 of a complete data byte. Chip select rising at any other point drops the write, and memory, status and the write-enable flag stay unchanged.
- R6: The write-enable flag is 0 after reset and is cleared by 0x04 and by the end of every write cycle. A write sent while the flag is 0 leaves memory unchanged.
- R7: After 0x06, every further byte in the same frame is ignored.
- R8: While hold is low, SCK and SI edges are ignored and SO is not driven. When hold is released, the transfer continues from the bit where it stopped.
- R9: SO is not driven while chip select is high. After reset, a falling edge of chip select is needed before any command is taken.
- R10: For `WCYC` clocks after a write cycle starts, status bit 0 reads 1. Every command except 0x05 is ignored during that time.
- R11: Status byte layout: bit 7 protect-enable, bits 3:2 block-protect, bit 1 write-enable flag, bit 0 busy, all other bits 0. Command 0x01 loads bits 7, 3 and 2.
- R12: Block-protect value 01 locks the top quarter of the array, 10 the top half and 11 all of it. Bytes aimed at locked addresses are not written.
- R13: When protect-enable is 1 and the write-protect pin is low, command 0x01 starts no cycle and the status bits stay as they are. With the pin high, the status write works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data into the block |
| spi_hold_n | input | 1 | Active-low pause |
| spi_wp_n | input | 1 | Active-low write-protect pin |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for SO (0 = high impedance) |

## Verification
The embedded assertions check on every cycle that:
- SO stays undriven while chip select is high.
- The bit counter and shift register stay frozen during a pause.
- A write cycle starts only from an idle state with the write-enable flag set.
- The flag is clear right after each cycle ends, and the busy span has its full length.

The bench scenarios show the rest:
- Data placement and both kinds of address wrap.
- The byte-boundary rule for committing a write.
- Block locking and status write refusal.
- The resumed bit position after a pause.
- Mode 3 operation.
- Silence after a reset taken with chip select already low.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_RD, PH_WR, PH_SRD, PH_SWR, PH_SKIP
  } phase_e;

  localparam logic [7:0] OP_WEL_SET = 8'h06;
  localparam logic [7:0] OP_WEL_CLR = 8'h04;
  localparam logic [7:0] OP_STAT_RD = 8'h05;
  localparam logic [7:0] OP_STAT_WR = 8'h01;
  localparam logic [7:0] OP_ARR_RD  = 8'h03;
  localparam logic [7:0] OP_ARR_WR  = 8'h02;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int W = 5,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        stab_q <= RST_VAL[g];
      end else begin
        meta_q <= d[g];
        stab_q <= meta_q;
      end
    end
    assign q[g] = stab_q;
  end
endmodule

// File: rtl/eep_wcycle.sv
module eep_wcycle #(
  parameter int CYC  = 400,
  parameter int PAGE = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  output logic                    busy,
  output logic                    done,
  output logic                    step_en,
  output logic [$clog2(PAGE)-1:0] step
);
  localparam int CW = $clog2(CYC);
  localparam int PW = $clog2(PAGE);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          busy_q, busy_n;

  always_comb begin
    cnt_n  = cnt_q;
    busy_n = busy_q;
    if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_n = 1'b0;
        cnt_n  = '0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end else if (start) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
    end
  end

  assign busy    = busy_q;
  assign done    = busy_q && (cnt_q == LAST);
  assign step_en = busy_q && (cnt_q < CW'(PAGE));
  assign step    = cnt_q[PW-1:0];

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);  // R10
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt_q) == LAST));  // R10
endmodule

// File: rtl/eep_protect.sv
module eep_protect #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp_n,
  input  logic          load,
  input  logic [2:0]    wdata,
  input  logic [AW-1:0] chk_addr,
  output logic          wpen,
  output logic [1:0]    bp,
  output logic          sr_ok,
  output logic          locked
);
  logic       wpen_q;
  logic [1:0] bp_q;
  logic [1:0] quarter;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpen_q <= 1'b0;
      bp_q   <= 2'b00;
    end else if (load) begin
      wpen_q <= wdata[2];
      bp_q   <= wdata[1:0];
    end
  end

  assign quarter = chk_addr[AW-1:AW-2];

  always_comb begin
    unique case (bp_q)
      2'b00:   locked = 1'b0;
      2'b01:   locked = (quarter == 2'b11);
      2'b10:   locked = quarter[1];
      default: locked = 1'b1;
    endcase
  end

  assign sr_ok = !(wpen_q && !wp_n);
  assign wpen  = wpen_q;
  assign bp    = bp_q;

  AST_BITS_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable({wpen_q, bp_q}));  // R11
endmodule

// File: rtl/spi_eep_slave.sv
module spi_eep_slave
  import eep_pkg::*;
#(
  parameter int AW   = 11,
  parameter int PAGE = 32,
  parameter int WCYC = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_si,
  input  logic spi_hold_n,
  input  logic spi_wp_n,
  output logic spi_so,
  output logic spi_so_oe
);
  localparam int PW    = $clog2(PAGE);
  localparam int PGW   = AW - PW;
  localparam int DEPTH = 1 << AW;
  localparam int HW    = AW - 8;

  // synchronized pins
  logic [4:0] pins_s;
  logic sck_s, cs_s, si_s, hold_s, wp_s;

  eep_sync #(.W(5), .RST_VAL(5'b11000)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_wp_n, spi_hold_n, spi_si, spi_cs_n, spi_sck}),
    .q(pins_s)
  );
  assign {wp_s, hold_s, si_s, cs_s, sck_s} = pins_s;

  // registers
  phase_e          phase_q, phase_n;
  logic [6:0]      shreg_q, shreg_n;
  logic [2:0]      bitcnt_q, bitcnt_n;
  logic            abyte_q, abyte_n;
  logic [HW-1:0]   ahi_q, ahi_n;
  logic [AW-1:0]   rdad_q, rdad_n;
  logic [7:0]      out_q, out_n;
  logic            so_q, so_n;
  logic            bdone_q, bdone_n;
  logic            wel_q, wel_n;
  logic            iswr_q, iswr_n;
  logic [PW-1:0]   wptr_q, wptr_n;
  logic [PGW-1:0]  wpage_q, wpage_n;
  logic [2:0]      pend_q, pend_n;
  logic            kst_q, kst_n;
  logic            armed_q, armed_n;
  logic            sck_q, cs_q;

  logic [7:0]      mem_q [DEPTH];
  logic [7:0]      pbuf_q [PAGE];
  logic [PAGE-1:0] pval_q;

  // edge detection and frame state
  logic hold_act, sck_rise, sck_fall, cs_fall, cs_rise, sel;
  logic bit_rx, bit_tx, byte_end;
  logic [7:0] byte_in, stat;
  logic [AW-1:0] a_new;
  logic buf_we, buf_clr;
  logic start_arr, start_st, wc_start;

  // submodule outputs
  logic wc_busy, wc_done, wc_step_en;
  logic [PW-1:0] wc_step;
  logic pr_wpen, pr_sr_ok, pr_locked;
  logic [1:0] pr_bp;
  logic [AW-1:0] commit_addr;
  logic mem_we;

  assign hold_act = !hold_s;
  assign sck_rise = sck_s && !sck_q && !hold_act;
  assign sck_fall = !sck_s && sck_q && !hold_act;
  assign cs_fall  = !cs_s && cs_q;
  assign cs_rise  = cs_s && !cs_q;
  assign sel      = armed_q && !cs_s;
  assign bit_rx   = sel && sck_rise;
  assign bit_tx   = sel && sck_fall;
  assign byte_in  = {shreg_q, si_s};
  assign byte_end = bit_rx && (bitcnt_q == 3'd7);
  assign a_new    = {ahi_q, byte_in};
  assign stat     = {pr_wpen, 3'b000, pr_bp, wel_q, wc_busy};

  assign start_arr = cs_rise && armed_q && (phase_q == PH_WR) && bdone_q
                     && wel_q && !wc_busy;
  assign start_st  = cs_rise && armed_q && (phase_q == PH_SWR) && bdone_q
                     && wel_q && pr_sr_ok && !wc_busy;
  assign wc_start  = start_arr || start_st;

  always_comb begin
    phase_n = phase_q;  shreg_n = shreg_q;  bitcnt_n = bitcnt_q;
    abyte_n = abyte_q;  ahi_n   = ahi_q;    rdad_n   = rdad_q;
    out_n   = out_q;    so_n    = so_q;     bdone_n  = bdone_q;
    wel_n   = wel_q;    iswr_n  = iswr_q;   wptr_n   = wptr_q;
    wpage_n = wpage_q;  pend_n  = pend_q;   kst_n    = kst_q;
    armed_n = armed_q || cs_fall;
    buf_we  = 1'b0;     buf_clr = 1'b0;

    if (cs_fall) begin
      phase_n  = PH_OPC;
      bitcnt_n = '0;
      abyte_n  = 1'b0;
      bdone_n  = 1'b0;
    end else if (cs_rise) begin
      phase_n = PH_SKIP;
    end else if (bit_rx) begin
      shreg_n  = byte_in[6:0];
      bitcnt_n = bitcnt_q + 1'b1;
      bdone_n  = 1'b0;
      if (bitcnt_q == 3'd7) begin
        unique case (phase_q)
          PH_OPC: begin
            phase_n = PH_SKIP;
            if (byte_in == OP_STAT_RD) begin
              phase_n = PH_SRD;
              out_n   = stat;
            end else if (!wc_busy) begin
              unique case (byte_in)
                OP_WEL_SET: wel_n = 1'b1;
                OP_WEL_CLR: wel_n = 1'b0;
                OP_STAT_WR: if (wel_q) phase_n = PH_SWR;
                OP_ARR_RD: begin
                  phase_n = PH_ADDR;
                  iswr_n  = 1'b0;
                end
                OP_ARR_WR: if (wel_q) begin
                  phase_n = PH_ADDR;
                  iswr_n  = 1'b1;
                end
                default: ;
              endcase
            end
          end
          PH_ADDR: begin
            if (!abyte_q) begin
              ahi_n   = byte_in[HW-1:0];
              abyte_n = 1'b1;
            end else if (iswr_q) begin
              phase_n = PH_WR;
              wptr_n  = a_new[PW-1:0];
              wpage_n = a_new[AW-1:PW];
              buf_clr = 1'b1;
            end else begin
              phase_n = PH_RD;
              out_n   = mem_q[a_new];
              rdad_n  = a_new + 1'b1;
            end
          end
          PH_RD: begin
            out_n  = mem_q[rdad_q];
            rdad_n = rdad_q + 1'b1;
          end
          PH_SRD: out_n = stat;
          PH_WR: begin
            buf_we  = 1'b1;
            wptr_n  = wptr_q + 1'b1;
            bdone_n = 1'b1;
          end
          PH_SWR: begin
            pend_n  = {byte_in[7], byte_in[3:2]};
            bdone_n = 1'b1;
          end
          default: ;
        endcase
      end
    end else if (bit_tx && (phase_q == PH_RD || phase_q == PH_SRD)) begin
      so_n  = out_q[7];
      out_n = {out_q[6:0], 1'b0};
    end

    if (wc_start) kst_n = start_st;
    if (wc_done)  wel_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SKIP;  shreg_q <= '0;  bitcnt_q <= '0;
      abyte_q <= 1'b0;     ahi_q   <= '0;  rdad_q   <= '0;
      out_q   <= '0;       so_q    <= 1'b0; bdone_q <= 1'b0;
      wel_q   <= 1'b0;     iswr_q  <= 1'b0; wptr_q  <= '0;
      wpage_q <= '0;       pend_q  <= '0;  kst_q    <= 1'b0;
      armed_q <= 1'b0;     sck_q   <= 1'b0; cs_q    <= 1'b0;
    end else begin
      phase_q <= phase_n;  shreg_q <= shreg_n;  bitcnt_q <= bitcnt_n;
      abyte_q <= abyte_n;  ahi_q   <= ahi_n;    rdad_q   <= rdad_n;
      out_q   <= out_n;    so_q    <= so_n;     bdone_q  <= bdone_n;
      wel_q   <= wel_n;    iswr_q  <= iswr_n;   wptr_q   <= wptr_n;
      wpage_q <= wpage_n;  pend_q  <= pend_n;   kst_q    <= kst_n;
      armed_q <= armed_n;  sck_q   <= sck_s;    cs_q     <= cs_s;
    end
  end

  // page buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pval_q <= '0;
    end else if (buf_clr) begin
      pval_q <= '0;
    end else if (buf_we) begin
      pval_q[wptr_q] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf_q[wptr_q] <= byte_in;
  end

  // self-timed cycle and commit
  eep_wcycle #(.CYC(WCYC), .PAGE(PAGE)) u_wcycle (
    .clk(clk), .rst_n(rst_n), .start(wc_start),
    .busy(wc_busy), .done(wc_done), .step_en(wc_step_en), .step(wc_step)
  );

  assign commit_addr = {wpage_q, wc_step};

  eep_protect #(.AW(AW)) u_protect (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_s),
    .load(wc_done && kst_q), .wdata(pend_q), .chk_addr(commit_addr),
    .wpen(pr_wpen), .bp(pr_bp), .sr_ok(pr_sr_ok), .locked(pr_locked)
  );

  assign mem_we = wc_step_en && !kst_q && pval_q[wc_step] && !pr_locked;

  always_ff @(posedge clk) begin
    if (mem_we) mem_q[commit_addr] <= pbuf_q[wc_step];
  end

  assign spi_so    = so_q;
  assign spi_so_oe = sel && hold_s && (phase_q == PH_RD || phase_q == PH_SRD);

  AST_SO_HIZ_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && $past(cs_s)) |-> !spi_so_oe);  // R9
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && hold_act && !cs_s && $past(!cs_s)) |=> ($stable(bitcnt_q) && $stable(shreg_q)));  // R8
  AST_CYCLE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wc_busy) |-> $past(wel_q));  // R6
  AST_WEL_CLEAR_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    wc_done |=> !wel_q);  // R6
endmodule

// File: tb/spi_eep_slave_test.sv
module spi_eep_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic so, so_oe;

  int total = 0, bad = 0;
  int hold_bit = -1;
  bit mode3 = 1'b0;
  bit oe_seen = 1'b0;
  bit finished = 1'b0;
  logic [7:0] rx, st;
  logic [7:0] dbuf [40];

  // waddr, raddr, data
  localparam logic [39:0] VEC [4] = '{
    {16'h0010, 16'h0010, 8'h5A},
    {16'hF805, 16'h0005, 8'hC3},
    {16'h0123, 16'h0123, 8'h01},
    {16'h03FF, 16'h03FF, 8'hFE}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_eep_slave uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .spi_hold_n(hold_n), .spi_wp_n(wp_n), .spi_so(so), .spi_so_oe(so_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nb, output logic [7:0] r);
    r = '0;
    for (int i = 7; i >= 8 - nb; i--) begin
      if (i == hold_bit) begin
        waitc(HP);
        hold_n = 1'b0;
        waitc(HP);
        check("R8 so released in pause", {7'd0, so_oe}, 8'd0);
        for (int k = 0; k < 3; k++) begin
          sck = 1'b1; si = ~si; waitc(HP);
          sck = 1'b0; waitc(HP);
        end
        hold_n = 1'b1;
        waitc(HP);
        hold_bit = -1;
      end
      if (mode3) sck = 1'b0;
      si = tx[i];
      waitc(HP);
      r[i] = so;
      if (so_oe) oe_seen = 1'b1;
      sck = 1'b1;
      waitc(HP);
      if (!mode3) sck = 1'b0;
    end
  endtask

  task automatic fbeg();
    if (mode3) sck = 1'b1;
    cs_n = 1'b0;
    waitc(HP);
  endtask

  task automatic fend();
    waitc(HP);
    cs_n = 1'b1;
    waitc(2*HP);
    if (mode3) begin sck = 1'b0; waitc(HP); end
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    fbeg(); xfer(op, 8, d); fend();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    fbeg(); xfer(8'h05, 8, d); xfer(8'h00, 8, s); fend();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 60; k++) begin
      rdsr(s);
      if (!s[0]) break;
    end
  endtask

  task automatic wr_frame(input logic [15:0] a, input int n, input bit close);
    logic [7:0] d;
    fbeg();
    xfer(8'h02, 8, d); xfer(a[15:8], 8, d); xfer(a[7:0], 8, d);
    for (int k = 0; k < n; k++) xfer(dbuf[k], 8, d);
    if (close) fend();
  endtask

  task automatic write_one(input logic [15:0] a, input logic [7:0] v);
    cmd1(8'h06);
    dbuf[0] = v;
    wr_frame(a, 1, 1'b1);
    wait_idle();
  endtask

  task automatic rd_frame(input logic [15:0] a, input int n);
    logic [7:0] d;
    fbeg();
    xfer(8'h03, 8, d); xfer(a[15:8], 8, d); xfer(a[7:0], 8, d);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 8, d);
      dbuf[k] = d;
    end
    fend();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    fbeg(); xfer(8'h01, 8, d); xfer(v, 8, d); fend();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R9: chip select held low through reset release: no command taken
    cs_n = 1'b0;
    waitc(5);
    rst_n = 1'b1;
    waitc(5);
    oe_seen = 1'b0;
    xfer(8'h05, 8, rx); xfer(8'h00, 8, rx);
    check("R9 no output without select edge", {7'd0, oe_seen}, 8'd0);
    cs_n = 1'b1;
    waitc(3*HP);
    check("R9 so undriven when deselected", {7'd0, so_oe}, 8'd0);
    rdsr(st);
    check("R11 R6 reset status", st, 8'h00);

    // R3 vector table: write then read back, upper address bits unused
    for (int v = 0; v < 4; v++) begin
      write_one(VEC[v][39:24], VEC[v][7:0]);
      rd_frame(VEC[v][23:8], 1);
      check("R3 R1 table readback", dbuf[0], VEC[v][7:0]);
    end

    // R3 read wraps from top to 0
    write_one(16'h07FF, 8'hA7);
    write_one(16'h0000, 8'h3C);
    rd_frame(16'h07FF, 2);
    check("R3 top byte", dbuf[0], 8'hA7);
    check("R3 wrap to 0", dbuf[1], 8'h3C);

    // R4 page wrap: start at offset 30 of page 0x040
    cmd1(8'h06);
    dbuf[0] = 8'h11; dbuf[1] = 8'h22; dbuf[2] = 8'h33;
    wr_frame(16'h005E, 3, 1'b1);
    wait_idle();
    rd_frame(16'h005E, 2);
    check("R4 offset 30", dbuf[0], 8'h11);
    check("R4 offset 31", dbuf[1], 8'h22);
    rd_frame(16'h0040, 1);
    check("R4 wrapped into page start", dbuf[0], 8'h33);

    // R4 33 bytes: last one replaces the first
    cmd1(8'h06);
    for (int k = 0; k < 33; k++) dbuf[k] = 8'(k + 1);
    wr_frame(16'h0060, 33, 1'b1);
    wait_idle();
    rd_frame(16'h0060, 2);
    check("R4 overwrite offset 0", dbuf[0], 8'd33);
    check("R4 offset 1 kept", dbuf[1], 8'd2);

    // R5 chip select rises mid byte
    cmd1(8'h06);
    dbuf[0] = 8'h99;
    wr_frame(16'h0010, 1, 1'b0);
    xfer(8'hFF, 3, rx);
    fend();
    rdsr(st);
    check("R5 no cycle, flag kept", st, 8'h02);
    rd_frame(16'h0010, 1);
    check("R5 memory unchanged", dbuf[0], 8'h5A);
    cmd1(8'h04);
    rdsr(st);
    check("R6 flag cleared by 0x04", st, 8'h00);

    // R6 write without flag
    dbuf[0] = 8'h22;
    wr_frame(16'h0010, 1, 1'b1);
    rdsr(st);
    check("R6 no cycle without flag", st, 8'h00);
    rd_frame(16'h0010, 1);
    check("R6 memory unchanged", dbuf[0], 8'h5A);

    // R7 write in same frame as 0x06
    fbeg();
    xfer(8'h06, 8, rx); xfer(8'h02, 8, rx); xfer(8'h00, 8, rx);
    xfer(8'h10, 8, rx); xfer(8'h11, 8, rx);
    fend();
    rdsr(st);
    check("R7 flag set, no cycle", st, 8'h02);
    rd_frame(16'h0010, 1);
    check("R7 memory unchanged", dbuf[0], 8'h5A);
    cmd1(8'h04);

    // R8 pause in the middle of a data byte
    fbeg();
    xfer(8'h03, 8, rx); xfer(8'h00, 8, rx); xfer(8'h10, 8, rx);
    hold_bit = 4;
    xfer(8'h00, 8, rx);
    fend();
    check("R8 byte after resume", rx, 8'h5A);

    // R2 mode 3
    mode3 = 1'b1;
    rd_frame(16'h0123, 1);
    check("R2 mode 3 read", dbuf[0], 8'h01);
    write_one(16'h0124, 8'h6D);
    rd_frame(16'h0123, 2);
    check("R2 mode 3 write", dbuf[1], 8'h6D);
    mode3 = 1'b0;

    // R10 busy: only status read answered
    cmd1(8'h06);
    dbuf[0] = 8'h44;
    wr_frame(16'h0200, 1, 1'b1);
    cmd1(8'h04);
    rdsr(st);
    check("R10 busy with flag kept", st, 8'h03);
    wait_idle();
    rdsr(st);
    check("R10 R6 idle after cycle", st, 8'h00);
    rd_frame(16'h0200, 1);
    check("R10 byte committed", dbuf[0], 8'h44);

    // R12 top half locked
    cmd1(8'h06);
    wrsr(8'h08);
    wait_idle();
    rdsr(st);
    check("R11 status after write", st, 8'h08);
    write_one(16'h07FF, 8'h55);
    rd_frame(16'h07FF, 1);
    check("R12 locked byte kept", dbuf[0], 8'hA7);
    write_one(16'h0123, 8'h77);
    rd_frame(16'h0123, 1);
    check("R12 open byte written", dbuf[0], 8'h77);

    // R13 pin refuses status write
    cmd1(8'h06);
    wrsr(8'h88);
    wait_idle();
    wp_n = 1'b0;
    cmd1(8'h06);
    wrsr(8'h00);
    wait_idle();
    rdsr(st);
    check("R13 refused status write", st, 8'h8A);
    wp_n = 1'b1;
    waitc(HP);
    wrsr(8'h00);
    wait_idle();
    rdsr(st);
    check("R13 status write with pin high", st, 8'h00);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule